// File: doc/BRIEF.md
# Over-Temperature Hysteresis Monitor

This block watches a linear temperature-sense voltage that an external converter has already digitised. Each qualified sample is an unsigned code referenced to a configurable full-scale voltage. The block turns the code into millivolts and then into a signed temperature in millidegrees Celsius. It uses the sensor line V = 0.019·T + 0.2 volts, minus a stored per-unit offset correction. The decoded temperature is compared against two programmable limits, a trip level and a lower release level. The result drives an active-low over-temperature flag with hysteresis, which the surrounding logic uses to request that PWM output be disabled.

Units of the sensor differ by up to about ±95 mV of offset but share one slope. A calibration strobe taken while the ambient temperature is known, before the motor starts, records that offset. Every later sample is corrected by it. Samples at or near the sensor's 5.2 V saturation are flagged as over-range and force the trip, because the temperature cannot be known there. A zero code is flagged as under-range and still decodes to a negative temperature.

Top module: `ot_monitor`

## Requirements
- R1: After reset the flag `ot_n` is 1, `temp_mc` is 0, `over_range` and `under_range` are 0, the offset correction is 0 mV, and the limits are trip 100 °C and release 80 °C.
- R2: On a cycle with `samp_valid` high, the block computes mv = floor(code·5500/4096) and temp = trunc((mv − 200 − offset)·1000/19), with division rounding toward zero. It shows temp on `temp_mc` from the next clock edge onward.
- R3: A strobed sample whose decoded temperature is at or above trip·1000 drives `ot_n` to 0 at the next clock edge.
- R4: `ot_n` returns to 1 only after a strobed sample whose decoded temperature is strictly below release·1000. A sample between the two limits keeps the flag unchanged.
- R5: Without `samp_valid`, `ot_n`, `temp_mc`, `over_range` and `under_range` keep their values, whatever the code input does.
- R6: A write (`cfg_wr` high) takes the new limits `cfg_trip_c`/`cfg_rel_c` (signed °C) only if release < trip. Any other write is ignored, and the previous limits stay in force.
- R7: A `cal_capture` strobe stores offset = mv − (200 + 19·`cal_amb_c`) mV, where mv is decoded from the code present in that cycle. The new offset applies from the next sample onward. A sample strobed in the same cycle still uses the old offset.
- R8: A strobed sample with mv ≥ 5150 sets `over_range` to 1 and drives `ot_n` to 0, whatever the limits are. Below 5150 mV, `over_range` is 0.
- R9: A strobed code of 0 sets `under_range` to 1 and reports the decoded negative temperature. Any other code sets `under_range` to 0.
- R10: A sample strobed in the same cycle as an accepted limit write is judged against the limits held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | Qualifies `samp_code` for a comparison |
| samp_code | input | 12 | Unsigned converter code, full scale 5500 mV |
| cfg_wr | input | 1 | Limit write strobe |
| cfg_trip_c | input | 10 | Signed trip limit in °C |
| cfg_rel_c | input | 10 | Signed release limit in °C |
| cal_capture | input | 1 | Offset calibration strobe, uses `samp_code` |
| cal_amb_c | input | 10 | Signed known ambient temperature in °C |
| ot_n | output | 1 | Active-low over-temperature flag, PWM-disable request |
| temp_mc | output | 32 | Signed decoded temperature in millidegrees |
| over_range | output | 1 | Last sample was at the sensor clamp |
| under_range | output | 1 | Last sample was a zero code |

## Verification
A sample strobe can land in the same cycle as a limit write, and also in the same cycle as an offset capture. In both cases the sample must be judged by the state held before the cycle. The bench provokes the first case with the flag low and a write whose new release level lies above the sample. The old limits hold the flag low, while the new ones would raise it. It provokes the second case by strobing and capturing on the same code, and it expects the old offset in that result and the new one only in the next sample. Random runs mix such coincident strobes at random, and a bench model tracks the limits and offset, applying them in that order.

// File: rtl/ot_pkg.sv
package ot_pkg;
   localparam int CALC_W = 32;
   typedef logic signed [CALC_W-1:0] calc_t;
   localparam calc_t MC_PER_C = 32'sd1000;
endpackage

// File: rtl/ot_decode.sv
module ot_decode
   import ot_pkg::*;
#(
   parameter int ADC_W    = 12,
   parameter int FS_MV    = 5500,
   parameter int V0_MV    = 200,
   parameter int SLOPE_MV = 19,
   parameter int CLAMP_MV = 5200,
   parameter int GUARD_MV = 50,
   parameter int OFF_W    = 16
) (
   input  logic [ADC_W-1:0]        code,
   input  logic signed [OFF_W-1:0] off,
   output calc_t                   mv,
   output calc_t                   temp_mc,
   output logic                    over,
   output logic                    under
);
   localparam calc_t OVR_MV = calc_t'(CLAMP_MV - GUARD_MV);

   if (ADC_W < 2 || ADC_W > 16) begin : g_bad_adc_w
      $error("ot_decode: ADC_W out of range");
   end
   if (FS_MV >= (1 << (31 - ADC_W))) begin : g_bad_fs
      $error("ot_decode: FS_MV too large for the product width");
   end
   if (SLOPE_MV <= 0) begin : g_bad_slope
      $error("ot_decode: SLOPE_MV must be positive");
   end
   if (FS_MV <= CLAMP_MV - GUARD_MV) begin : g_bad_clamp
      $error("ot_decode: clamp window outside the full-scale range");
   end

   logic [CALC_W-1:0] prod;

   always_comb begin
      prod    = CALC_W'(code) * CALC_W'(FS_MV);
      mv      = calc_t'(prod >> ADC_W);
      temp_mc = ((mv - calc_t'(V0_MV) - calc_t'(off)) * MC_PER_C) / calc_t'(SLOPE_MV);
      over    = (mv >= OVR_MV);
      under   = (code == '0);
   end
endmodule

// File: rtl/ot_offset.sv
module ot_offset
   import ot_pkg::*;
#(
   parameter int TEMP_W   = 10,
   parameter int OFF_W    = 16,
   parameter int V0_MV    = 200,
   parameter int SLOPE_MV = 19
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cal,
   input  calc_t                    mv,
   input  logic signed [TEMP_W-1:0] amb_c,
   output logic signed [OFF_W-1:0]  off
);
   if (OFF_W < 8 || OFF_W > 31) begin : g_bad_off_w
      $error("ot_offset: OFF_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off <= '0;
      end else if (cal) begin
         off <= OFF_W'(mv - calc_t'(V0_MV) - calc_t'(amb_c) * calc_t'(SLOPE_MV));
      end
   end

   // R7: the correction moves only on a capture strobe
   a_r7_offset_held: assert property (@(posedge clk) disable iff (!rst_n)
      !cal |=> $stable(off));
endmodule

// File: rtl/ot_limits.sv
module ot_limits #(
   parameter int TEMP_W   = 10,
   parameter int TRIP_DEF = 100,
   parameter int REL_DEF  = 80
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic signed [TEMP_W-1:0] trip_in,
   input  logic signed [TEMP_W-1:0] rel_in,
   output logic signed [TEMP_W-1:0] trip_q,
   output logic signed [TEMP_W-1:0] rel_q
);
   localparam int T_MAX = (1 << (TEMP_W - 1)) - 1;
   localparam int T_MIN = -(1 << (TEMP_W - 1));

   if (REL_DEF >= TRIP_DEF) begin : g_bad_order
      $error("ot_limits: default release must lie below default trip");
   end
   if (TRIP_DEF > T_MAX || REL_DEF < T_MIN) begin : g_bad_range
      $error("ot_limits: default limits do not fit TEMP_W");
   end

   logic ordered;
   assign ordered = (rel_in < trip_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trip_q <= TEMP_W'(TRIP_DEF);
         rel_q  <= TEMP_W'(REL_DEF);
      end else if (wr && ordered) begin
         trip_q <= trip_in;
         rel_q  <= rel_in;
      end
   end

   // R6: the held pair always keeps release below trip
   a_r6_order_kept: assert property (@(posedge clk) disable iff (!rst_n)
      rel_q < trip_q);
   // R6: a write with release >= trip leaves both limits untouched
   a_r6_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !(rel_in < trip_in)) |=> ($stable(trip_q) && $stable(rel_q)));
endmodule

// File: rtl/ot_hyst.sv
module ot_hyst
   import ot_pkg::*;
#(
   parameter int TEMP_W   = 10,
   parameter bit OVR_TRIP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld,
   input  calc_t                    temp_mc,
   input  logic                     over,
   input  logic                     under,
   input  logic signed [TEMP_W-1:0] trip_c,
   input  logic signed [TEMP_W-1:0] rel_c,
   output logic                     ot_n,
   output calc_t                    temp_q,
   output logic                     over_q,
   output logic                     under_q
);
   calc_t trip_mc, rel_mc;
   logic  set_ot, clr_ot;

   assign trip_mc = calc_t'(trip_c) * MC_PER_C;
   assign rel_mc  = calc_t'(rel_c) * MC_PER_C;

   if (OVR_TRIP) begin : g_ovr_trips
      assign set_ot = over || (temp_mc >= trip_mc);
      assign clr_ot = !over && (temp_mc < rel_mc);
      // R8: a clamped sample always asserts the flag
      a_r8_over_trips: assert property (@(posedge clk) disable iff (!rst_n)
         (vld && over) |=> !ot_n);
   end else begin : g_ovr_holds
      assign set_ot = !over && (temp_mc >= trip_mc);
      assign clr_ot = !over && (temp_mc < rel_mc);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ot_n    <= 1'b1;
         temp_q  <= '0;
         over_q  <= 1'b0;
         under_q <= 1'b0;
      end else if (vld) begin
         temp_q  <= temp_mc;
         over_q  <= over;
         under_q <= under;
         if (set_ot) begin
            ot_n <= 1'b0;
         end else if (clr_ot) begin
            ot_n <= 1'b1;
         end
      end
   end

   // R5: outputs move only after a qualified sample
   a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |=> ($stable(ot_n) && $stable(temp_q) && $stable(over_q) && $stable(under_q)));
   // R3: the flag falls only for a sample at or above trip, or clamped
   a_r3_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ot_n) |-> $past(over || (temp_mc >= trip_mc)));
   // R4: the flag rises only for an unclamped sample below release
   a_r4_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ot_n) |-> $past(!over && (temp_mc < rel_mc)));
endmodule

// File: rtl/ot_monitor.sv
module ot_monitor
   import ot_pkg::*;
#(
   parameter int ADC_W    = 12,
   parameter int FS_MV    = 5500,
   parameter int V0_MV    = 200,
   parameter int SLOPE_MV = 19,
   parameter int CLAMP_MV = 5200,
   parameter int GUARD_MV = 50,
   parameter int TEMP_W   = 10,
   parameter int OFF_W    = 16,
   parameter int TRIP_DEF = 100,
   parameter int REL_DEF  = 80,
   parameter bit OVR_TRIP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     samp_valid,
   input  logic [ADC_W-1:0]         samp_code,
   input  logic                     cfg_wr,
   input  logic signed [TEMP_W-1:0] cfg_trip_c,
   input  logic signed [TEMP_W-1:0] cfg_rel_c,
   input  logic                     cal_capture,
   input  logic signed [TEMP_W-1:0] cal_amb_c,
   output logic                     ot_n,
   output logic signed [CALC_W-1:0] temp_mc,
   output logic                     over_range,
   output logic                     under_range
);
   calc_t                    dec_mv, dec_temp, temp_q;
   logic                     dec_over, dec_under;
   logic signed [OFF_W-1:0]  off;
   logic signed [TEMP_W-1:0] trip_c, rel_c;

   ot_decode #(
      .ADC_W(ADC_W), .FS_MV(FS_MV), .V0_MV(V0_MV), .SLOPE_MV(SLOPE_MV),
      .CLAMP_MV(CLAMP_MV), .GUARD_MV(GUARD_MV), .OFF_W(OFF_W)
   ) u_decode (
      .code(samp_code), .off(off), .mv(dec_mv), .temp_mc(dec_temp),
      .over(dec_over), .under(dec_under)
   );

   ot_offset #(
      .TEMP_W(TEMP_W), .OFF_W(OFF_W), .V0_MV(V0_MV), .SLOPE_MV(SLOPE_MV)
   ) u_offset (
      .clk(clk), .rst_n(rst_n), .cal(cal_capture), .mv(dec_mv),
      .amb_c(cal_amb_c), .off(off)
   );

   ot_limits #(
      .TEMP_W(TEMP_W), .TRIP_DEF(TRIP_DEF), .REL_DEF(REL_DEF)
   ) u_limits (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .trip_in(cfg_trip_c),
      .rel_in(cfg_rel_c), .trip_q(trip_c), .rel_q(rel_c)
   );

   ot_hyst #(
      .TEMP_W(TEMP_W), .OVR_TRIP(OVR_TRIP)
   ) u_hyst (
      .clk(clk), .rst_n(rst_n), .vld(samp_valid), .temp_mc(dec_temp),
      .over(dec_over), .under(dec_under), .trip_c(trip_c), .rel_c(rel_c),
      .ot_n(ot_n), .temp_q(temp_q), .over_q(over_range), .under_q(under_range)
   );

   assign temp_mc = temp_q;

   // R9: a zero code is never reported as clamped
   a_r9_under_not_over: assert property (@(posedge clk) disable iff (!rst_n)
      !(under_range && over_range));
endmodule

// File: tb/ot_monitor_test.sv
`timescale 1ns/1ps
module ot_monitor_test;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              samp_valid = 1'b0;
   logic [11:0]       samp_code = '0;
   logic              cfg_wr = 1'b0;
   logic signed [9:0] cfg_trip_c = '0;
   logic signed [9:0] cfg_rel_c = '0;
   logic              cal_capture = 1'b0;
   logic signed [9:0] cal_amb_c = '0;
   logic              ot_n;
   logic signed [31:0] temp_mc;
   logic              over_range, under_range;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   int m_trip = 100, m_rel = 80, m_off = 0;
   int m_ot = 1, m_t = 0, m_ov = 0, m_un = 0;

   always #4 clk = ~clk;

   ot_monitor uut (
      .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_code(samp_code),
      .cfg_wr(cfg_wr), .cfg_trip_c(cfg_trip_c), .cfg_rel_c(cfg_rel_c),
      .cal_capture(cal_capture), .cal_amb_c(cal_amb_c), .ot_n(ot_n),
      .temp_mc(temp_mc), .over_range(over_range), .under_range(under_range)
   );

   function automatic int mv_of(int c);
      return (c * 5500) / 4096;
   endfunction

   function automatic int tmc(int c, int off);
      return ((mv_of(c) - 200 - off) * 1000) / 19;
   endfunction

   function automatic int first_code_at(int lim_mc, int off);
      for (int c = 0; c < 4096; c++) begin
         if (tmc(c, off) >= lim_mc) return c;
      end
      return 4095;
   endfunction

   function automatic int first_code_over();
      for (int c = 0; c < 4096; c++) begin
         if (mv_of(c) >= 5150) return c;
      end
      return 4095;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req);
      chk(req, "ot_n", int'(ot_n), m_ot);
      chk(req, "temp_mc", int'(temp_mc), m_t);
      chk(req, "over_range", int'(over_range), m_ov);
      chk(req, "under_range", int'(under_range), m_un);
   endtask

   // one clock: drive at a falling edge, check after the next rising edge
   task automatic step(int c, bit v, bit w, int tr, int rl, bit cal, int amb, string req);
      if (v) begin
         m_t  = tmc(c, m_off);
         m_ov = (mv_of(c) >= 5150) ? 1 : 0;
         m_un = (c == 0) ? 1 : 0;
         if (m_ov == 1 || m_t >= m_trip * 1000) m_ot = 0;
         else if (m_t < m_rel * 1000) m_ot = 1;
      end
      if (w && rl < tr) begin
         m_trip = tr;
         m_rel  = rl;
      end
      if (cal) m_off = mv_of(c) - (200 + 19 * amb);
      samp_code   = 12'(c);
      samp_valid  = v;
      cfg_wr      = w;
      cfg_trip_c  = 10'(tr);
      cfg_rel_c   = 10'(rl);
      cal_capture = cal;
      cal_amb_c   = 10'(amb);
      @(negedge clk);
      samp_valid  = 1'b0;
      cfg_wr      = 1'b0;
      cal_capture = 1'b0;
      check_all(req);
   endtask

   task automatic sample(int c, string req);
      step(c, 1'b1, 1'b0, 0, 0, 1'b0, 0, req);
   endtask

   task automatic write_lim(int tr, int rl, string req);
      step(int'($urandom_range(0, 4095)), 1'b0, 1'b1, tr, rl, 1'b0, 0, req);
   endtask

   task automatic idle(int n, string req);
      for (int i = 0; i < n; i++) begin
         step(int'($urandom_range(0, 4095)), 1'b0, 1'b0, 0, 0, 1'b0, 0, req);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=expired expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int c_trip, c_rel, c_70, c_ovr, r;
      void'($urandom(32'd7531));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_all("R1");

      // R2 and R1 (zero offset): a room-temperature code
      sample(503, "R2");
      chk("R2", "temp_mc 25C", int'(temp_mc), 25000);

      // R3: the trip edge
      c_trip = first_code_at(100000, 0);
      sample(c_trip - 1, "R3");
      chk("R3", "ot_n below trip", int'(ot_n), 1);
      sample(c_trip, "R3");
      chk("R3", "ot_n at trip", int'(ot_n), 0);

      // R4: the band holds, below release clears
      c_rel = first_code_at(80000, 0);
      sample(c_rel, "R4");
      chk("R4", "ot_n in band", int'(ot_n), 0);
      sample(c_rel - 1, "R4");
      chk("R4", "ot_n below release", int'(ot_n), 1);

      // R5: no strobe, no change
      sample(c_trip + 5, "R3");
      idle(6, "R5");
      chk("R5", "ot_n held", int'(ot_n), 0);
      sample(503, "R4");

      // R6: rejected writes leave 100/80 in force
      c_70 = first_code_at(70000, 0);
      write_lim(60, 60, "R6");
      write_lim(50, 55, "R6");
      sample(c_70, "R6");
      chk("R6", "ot_n old limits", int'(ot_n), 1);
      write_lim(60, 40, "R6");
      sample(c_70, "R6");
      chk("R6", "ot_n new limits", int'(ot_n), 0);

      // R10: write and strobe in the same cycle use the old limits
      step(c_70, 1'b1, 1'b1, 120, 110, 1'b0, 0, "R10");
      chk("R10", "ot_n same cycle", int'(ot_n), 0);
      sample(c_70, "R10");
      chk("R10", "ot_n after write", int'(ot_n), 1);

      // R8: clamp region
      sample(4095, "R8");
      chk("R8", "over at full scale", int'(over_range), 1);
      sample(503, "R8");
      c_ovr = first_code_over();
      sample(c_ovr - 1, "R8");
      chk("R8", "over below clamp window", int'(over_range), 0);
      sample(c_ovr, "R8");
      chk("R8", "ot_n on clamp", int'(ot_n), 0);

      // R9: zero code
      sample(0, "R9");
      chk("R9", "negative temp", int'(temp_mc), -10526);
      sample(1, "R9");

      // R7: capture with a strobe in the same cycle
      step(560, 1'b1, 1'b0, 0, 0, 1'b1, 25, "R7");
      chk("R7", "old offset same cycle", int'(temp_mc), 29000);
      sample(560, "R7");
      chk("R7", "new offset applied", int'(temp_mc), 25000);

      write_lim(100, 80, "R6");

      // random mix
      for (int i = 0; i < 600; i++) begin
         r = int'($urandom_range(0, 19));
         if (r < 2) begin
            int tr = int'($urandom_range(30, 140));
            write_lim(tr, tr - 20 + int'($urandom_range(0, 29)), "R6");
         end else if (r == 2) begin
            step(int'($urandom_range(480, 530)), 1'($urandom_range(0, 1)), 1'b0, 0, 0,
                 1'b1, int'($urandom_range(15, 35)), "R7");
         end else if (r == 3) begin
            int tr = int'($urandom_range(40, 130));
            step(int'($urandom_range(300, 2600)), 1'b1, 1'b1, tr, tr - 15, 1'b0, 0, "R10");
         end else if (r == 4) begin
            idle(int'($urandom_range(1, 3)), "R5");
         end else if (r == 5) begin
            sample((($urandom_range(0, 1)) != 0) ? 0 : int'($urandom_range(3800, 4095)), "R8");
         end else begin
            sample(int'($urandom_range(300, 2600)), "R2");
         end
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule